// File: doc/BRIEF.md
# Multicycle Instruction Phase Sequencer

This block is the control sequencer for a processor that does not overlap instructions. It moves a single instruction through four ordered phases: instruction fetch, operand fetch, execute and write back. It spends one clock in each phase and drives one enable line per phase. The datapath uses these lines to decide which of its sections may update on the current clock.

The state is one-hot, with one flip-flop for each phase. Slow instruction memory can stretch the fetch phase by holding a ready input low, which inserts wait states. A global run enable freezes the whole sequencer. An instruction-done strobe is high for the single cycle in which write back is active.

Top module: `phase_sequencer`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the next state is fetch: `phase_en` equals 4'b0001 (bit 0 fetch, bit 1 operand fetch, bit 2 execute, bit 3 write back) and `instr_done` is 0.
- R2: With `run_en` high and no wait state pending, the phases advance one per clock in the order fetch, operand fetch, execute, write back, then back to fetch.
- R3: After reset, exactly one bit of `phase_en` is high in every cycle.
- R4: While fetch is active and `mem_ready` is 0 (with `run_en` 1), the sequencer stays in fetch and no other enable rises. It advances to operand fetch on the first clock at which `mem_ready` is 1.
- R5: With `run_en` and `mem_ready` held high, `instr_done` pulses once every 4 clocks.
- R6: `instr_done` is 1 exactly in the cycles where `phase_en` is 4'b1000.
- R7: While `run_en` is 0, `phase_en` and `instr_done` hold their values, whatever `mem_ready` does.
- R8: `mem_ready` has no effect in the operand fetch, execute or write back phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global advance enable |
| mem_ready | input | 1 | Instruction memory ready; low stretches fetch |
| phase_en | output | 4 | One-hot phase enables, bit 0 = fetch |
| instr_done | output | 1 | High during the write back cycle |

## Verification
A corrupted phase flop is visible directly on `phase_en`, because the outputs are the state flops themselves. A dropped bit shows no enable in that same cycle, and an extra bit shows two enables. The recovery logic forces fetch one clock later. A wrong advance rule shows up within one clock of the stimulus that provokes it: a missing wait state, an ignored `run_en`, or a ready that leaks into later phases. A mistimed `instr_done` becomes visible when it fails to coincide with bit 3.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned SEQ_PHASES = 4;
  localparam int unsigned PH_FETCH   = 0;
  localparam int unsigned PH_OPERAND = 1;
  localparam int unsigned PH_EXEC    = 2;
  localparam int unsigned PH_WRITE   = 3;
endpackage

// File: rtl/phase_next_logic.sv
module phase_next_logic #(
  parameter int unsigned NUM_PHASES = seq_pkg::SEQ_PHASES,
  parameter int unsigned WAIT_PHASE = seq_pkg::PH_FETCH
) (
  input  logic [NUM_PHASES-1:0] cur_state,
  input  logic                  run_en,
  input  logic                  mem_ready,
  output logic [NUM_PHASES-1:0] nxt_state
);
  localparam logic [NUM_PHASES-1:0] HOME_VEC = NUM_PHASES'(1);

  logic legal;
  logic stall;

  always_comb begin
    legal = $onehot(cur_state);
    stall = cur_state[WAIT_PHASE] && !mem_ready;
    nxt_state = cur_state;
    if (!legal) begin
      nxt_state = HOME_VEC;
    end else if (run_en && !stall) begin
      nxt_state = {cur_state[NUM_PHASES-2:0], cur_state[NUM_PHASES-1]};
    end
  end
endmodule

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int unsigned NUM_PHASES = seq_pkg::SEQ_PHASES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PHASES-1:0] nxt_state,
  output logic [NUM_PHASES-1:0] state_q,
  output logic                  last_q
);
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_flop
    localparam logic RST_VAL = (g == 0);
    always_ff @(posedge clk) begin
      if (rst) state_q[g] <= RST_VAL;
      else     state_q[g] <= nxt_state[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= nxt_state[NUM_PHASES-1];
  end
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer #(
  parameter int unsigned NUM_PHASES = seq_pkg::SEQ_PHASES,
  parameter int unsigned WAIT_PHASE = seq_pkg::PH_FETCH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_en,
  input  logic                  mem_ready,
  output logic [NUM_PHASES-1:0] phase_en,
  output logic                  instr_done
);
  localparam logic [NUM_PHASES-1:0] HOME_VEC = NUM_PHASES'(1);

  logic [NUM_PHASES-1:0] state_q;
  logic [NUM_PHASES-1:0] nxt_state;
  logic                  last_q;

  phase_next_logic #(.NUM_PHASES(NUM_PHASES), .WAIT_PHASE(WAIT_PHASE)) i_next (
    .cur_state(state_q), .run_en(run_en), .mem_ready(mem_ready), .nxt_state(nxt_state)
  );

  phase_ring #(.NUM_PHASES(NUM_PHASES)) i_ring (
    .clk(clk), .rst(rst), .nxt_state(nxt_state), .state_q(state_q), .last_q(last_q)
  );

  assign phase_en   = state_q;
  assign instr_done = last_q;

  logic seen_reset;
  always_ff @(posedge clk) begin
    if (rst) seen_reset <= 1'b1;
  end

  assert_reset_home_R1: assert property (@(posedge clk)
    rst |=> (phase_en == HOME_VEC && !instr_done));

  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst || !seen_reset)
    $onehot(phase_en));

  assert_done_last_R6: assert property (@(posedge clk) disable iff (rst || !seen_reset)
    instr_done == phase_en[NUM_PHASES-1]);

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst || !seen_reset)
    (run_en && phase_en[WAIT_PHASE] && !mem_ready) |=> $stable(phase_en));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (rst || !seen_reset)
    (!run_en && $onehot(phase_en)) |=> ($stable(phase_en) && $stable(instr_done)));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst || !seen_reset)
    (run_en && phase_en[NUM_PHASES-1]) |=> (phase_en == HOME_VEC));
endmodule

// File: tb/test_phase_sequencer.sv
module test_phase_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, run_en, mem_ready;
  logic [3:0] phase_en;
  logic instr_done;
  int checks = 0;
  int errors = 0;
  int exp_idx = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_sequencer i_phase_sequencer (
    .clk(clk), .rst(rst), .run_en(run_en), .mem_ready(mem_ready),
    .phase_en(phase_en), .instr_done(instr_done)
  );

  task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [3:0] e;
    e = 4'b0001 << exp_idx;
    check(phase_en == e && instr_done == (exp_idx == 3), req,
          {instr_done, phase_en}, {exp_idx == 3, e});
  endtask

  task automatic adv_check(input string req);
    step();
    exp_idx = (exp_idx + 1) % 4;
    check_state(req);
  endtask

  task automatic t_reset();
    rst = 1'b1; run_en = 1'b1; mem_ready = 1'b1;
    step(); step();
    rst = 1'b0;
    exp_idx = 0;
    check_state("R1 reset state");
  endtask

  task automatic t_order();
    for (int k = 0; k < 8; k++) begin
      adv_check("R2 phase order");
      check($onehot(phase_en), "R3 one-hot", {1'b0, phase_en}, 5'b0);
    end
  endtask

  task automatic t_wait();
    mem_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      check_state("R4 fetch wait hold");
    end
    mem_ready = 1'b1;
    adv_check("R4 leave fetch when ready");
  endtask

  task automatic t_ready_ignored();
    mem_ready = 1'b0;
    adv_check("R8 ready ignored in execute");
    adv_check("R8 ready ignored in write back");
    adv_check("R8 ready ignored leaving write back");
    step();
    check_state("R4 stall on return to fetch");
    mem_ready = 1'b1;
  endtask

  task automatic t_freeze();
    adv_check("R7 setup");
    run_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      mem_ready = k[0];
      step();
      check_state("R7 frozen");
    end
    mem_ready = 1'b1;
    run_en = 1'b1;
    adv_check("R7 resume");
  endtask

  task automatic t_rate();
    int gap;
    while (!instr_done) adv_check("R6 advance to done");
    gap = 0;
    do begin
      adv_check("R6 done with write back");
      gap++;
    end while (!instr_done && gap < 10);
    check(gap == 4, "R5 done period", 5'(gap), 5'd4);
  endtask

  task automatic t_mid_reset();
    while (exp_idx != 2) adv_check("R1 setup");
    rst = 1'b1;
    step();
    rst = 1'b0;
    exp_idx = 0;
    check_state("R1 reset mid-instruction");
    adv_check("R2 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; run_en = 1'b0; mem_ready = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_wait();
    t_ready_ignored();
    t_freeze();
    t_rate();
    t_mid_reset();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule